// File: doc/BRIEF.md
# Run-Time Clock Generator Reprogramming Controller

This block lets software change the settings of an on-chip clock generator while the chip runs. Software reaches it through an AXI4-Lite slave with 32-bit data. The slave holds a bank of configuration words, a control register, a status register and a software reset register. At reset, each configuration word takes a default value fixed at build time, so a valid setting is always stored. Software then overwrites the words it needs.

Software first rewrites the whole configuration bank. It then writes the control register with both its enable bit and its load bit set. A sequencer then sends each stored word, one at a time, to the generator's reprogramming port. That port has a 7-bit address, 16-bit write data, 16-bit read data, an enable strobe, a write-enable strobe and a ready acknowledge. The controller holds the generator in reset while the port writes are in progress. It holds every generated clock output in reset until the generator reports lock again.

The port runs on the same clock as the register interface.

Top module: `clk_reconfig_ctrl`

## Requirements
- R1: After reset, configuration word i (at byte offset 0x200 + 4*i) reads back as 0x1041 + i*0x0203 (low 16 bits, upper 16 bits zero). The port enable, generator reset and clock-hold outputs are low, and status bit 1 (busy) is 0.
- R2: A write to configuration word i updates byte 0 when strobe bit 0 is set and byte 1 when strobe bit 1 is set. Reads return the stored 16 bits in bits [15:0] with zeros above.
- R3: Every write gets response OKAY (2'b00). Reads of offsets that map to nothing, including misaligned configuration offsets, return zero. A write response stays valid until it is accepted.
- R4: The control register at offset 0x014 holds bit 0 (enable) and bit 1 (load). A sequence starts only when both bits are set. Any other value is stored and read back, and has no effect on the port. Once a sequence starts, the register reads back 0.
- R5: A sequence makes exactly NUM_CFG port writes, in index order. Write i drives address 0x08 + i and data equal to configuration word i. Each enable lasts one cycle with write-enable high. No enable is issued while an earlier write is still waiting for its ready.
- R6: The generator reset output is high whenever the port enable is high. The clock-hold output is high from the start of a sequence until lock is observed after the last write.
- R7: Status register bit 0 at offset 0x004 mirrors the lock input. When lock is observed after the last ready, status bit 1 (busy) and the clock-hold output both fall.
- R8: While a sequence is active, configuration writes receive OKAY but leave the stored words unchanged.
- R9: Writing 0x0000000A with all four strobes set to offset 0x000 aborts any sequence and restores the defaults. It also drives the generator reset output high for exactly RST_PULSE cycles. Any other value written there has no effect.
- R10: Status bits [31:16] hold the port read data captured with the most recent ready acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and port clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | 12 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 12 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| port_addr_o | output | 7 | Reprogramming port address |
| port_wdata_o | output | 16 | Reprogramming port write data |
| port_rdata_i | input | 16 | Reprogramming port read data |
| port_en_o | output | 1 | Port transfer enable strobe |
| port_we_o | output | 1 | Port write enable |
| port_rdy_i | input | 1 | Port ready acknowledge |
| gen_rst_o | output | 1 | Reset to the clock generator |
| clk_hold_o | output | 1 | Holds all generated clocks in reset |
| gen_locked_i | input | 1 | Generator lock indication |

## Verification
The bench builds the block with NUM_CFG = 6 and RST_PULSE = 3. Six words is not a power of two, so the sequencer's last-index compare and the out-of-range offset 0x218 are exercised. The short pulse makes the exact length of the software reset pulse cheap to measure. The bench pairs the block with a responder that acknowledges each write after two cycles and returns the inverted data. It also models lock as dropping under reset and returning eight cycles later. This makes the abort of a running sequence, writes made during a sequence, and the lock-gated release all observable.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int unsigned AXI_AW  = 12;
    localparam int unsigned AXI_DW  = 32;
    localparam int unsigned PORT_AW = 7;
    localparam int unsigned PORT_DW = 16;

    localparam logic [AXI_AW-1:0] OFS_SWRST    = 12'h000;
    localparam logic [AXI_AW-1:0] OFS_STATUS   = 12'h004;
    localparam logic [AXI_AW-1:0] OFS_CTRL     = 12'h014;
    localparam logic [AXI_AW-1:0] OFS_CFG_BASE = 12'h200;

    localparam logic [AXI_DW-1:0] SWRST_KEY = 32'h0000_000A;
    localparam logic [1:0]        RESP_OKAY = 2'b00;
    localparam logic [1:0]        CTRL_GO   = 2'b11;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT_RDY,
        SQ_WAIT_LOCK
    } seq_state_e;

    typedef struct packed {
        logic [PORT_AW-1:0] addr;
        logic [PORT_DW-1:0] data;
    } port_xfer_t;

    // Build-time default setting for configuration word idx
    function automatic logic [PORT_DW-1:0] cfg_default(input int unsigned idx);
        return 16'h1041 + 16'(idx) * 16'h0203;
    endfunction

    // Fixed port address used for configuration word idx
    function automatic logic [PORT_AW-1:0] cfg_port_addr(input int unsigned idx);
        return 7'h08 + 7'(idx);
    endfunction

endpackage

// File: rtl/clkcfg_axil_regs.sv
module clkcfg_axil_regs
    import clkcfg_pkg::*;
#(
    parameter int unsigned NUM_CFG = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [AXI_AW-1:0]            s_awaddr,
    input  logic                         s_awvalid,
    output logic                         s_awready,
    input  logic [AXI_DW-1:0]            s_wdata,
    input  logic [3:0]                   s_wstrb,
    input  logic                         s_wvalid,
    output logic                         s_wready,
    output logic [1:0]                   s_bresp,
    output logic                         s_bvalid,
    input  logic                         s_bready,
    input  logic [AXI_AW-1:0]            s_araddr,
    input  logic                         s_arvalid,
    output logic                         s_arready,
    output logic [AXI_DW-1:0]            s_rdata,
    output logic [1:0]                   s_rresp,
    output logic                         s_rvalid,
    input  logic                         s_rready,
    input  logic                         busy_i,
    input  logic                         locked_i,
    input  logic [PORT_DW-1:0]           rd_cap_i,
    output logic [NUM_CFG-1:0][PORT_DW-1:0] cfg_o,
    output logic                         start_o,
    output logic                         soft_rst_o
);

    localparam logic [AXI_AW-1:0] CFG_END = OFS_CFG_BASE + AXI_AW'(4 * NUM_CFG);

    logic                wr_go, rd_go;
    logic                bvalid_q, rvalid_q;
    logic [AXI_DW-1:0]   rdata_q, rd_val;
    logic [1:0]          ctrl_q;
    logic                srst;
    logic [AXI_AW-1:0]   woff, roff;
    logic                w_cfg_hit, r_cfg_hit;

    assign srst  = rst | soft_rst_o;
    assign wr_go = s_awvalid & s_wvalid & ~bvalid_q;
    assign rd_go = s_arvalid & ~rvalid_q;

    assign s_awready = wr_go;
    assign s_wready  = wr_go;
    assign s_bvalid  = bvalid_q;
    assign s_bresp   = RESP_OKAY;
    assign s_arready = rd_go;
    assign s_rvalid  = rvalid_q;
    assign s_rdata   = rdata_q;
    assign s_rresp   = RESP_OKAY;

    assign woff      = s_awaddr - OFS_CFG_BASE;
    assign roff      = s_araddr - OFS_CFG_BASE;
    assign w_cfg_hit = (s_awaddr >= OFS_CFG_BASE) && (s_awaddr < CFG_END) && (s_awaddr[1:0] == 2'b00);
    assign r_cfg_hit = (s_araddr >= OFS_CFG_BASE) && (s_araddr < CFG_END) && (s_araddr[1:0] == 2'b00);

    assign start_o = (ctrl_q == CTRL_GO) && !busy_i;

    // Handshake state survives the software reset so its own response completes
    always_ff @(posedge clk) begin
        if (rst) begin
            bvalid_q   <= 1'b0;
            rvalid_q   <= 1'b0;
            rdata_q    <= '0;
            soft_rst_o <= 1'b0;
        end else begin
            soft_rst_o <= wr_go && (s_awaddr == OFS_SWRST) && (s_wstrb == 4'hF)
                          && (s_wdata == SWRST_KEY);
            if (wr_go)
                bvalid_q <= 1'b1;
            else if (s_bready)
                bvalid_q <= 1'b0;
            if (rd_go) begin
                rvalid_q <= 1'b1;
                rdata_q  <= rd_val;
            end else if (s_rready) begin
                rvalid_q <= 1'b0;
            end
        end
    end

    // Control register: self-clears when a sequence starts
    always_ff @(posedge clk) begin
        if (srst)
            ctrl_q <= '0;
        else if (start_o)
            ctrl_q <= '0;
        else if (wr_go && !busy_i && (s_awaddr == OFS_CTRL) && s_wstrb[0])
            ctrl_q <= s_wdata[1:0];
    end

    // User configuration set, seeded from the build-time defaults
    always_ff @(posedge clk) begin
        for (int unsigned i = 0; i < NUM_CFG; i++) begin
            if (srst) begin
                cfg_o[i] <= cfg_default(i);
            end else if (wr_go && !busy_i && w_cfg_hit && (woff[AXI_AW-1:2] == 10'(i))) begin
                if (s_wstrb[0]) cfg_o[i][7:0]  <= s_wdata[7:0];
                if (s_wstrb[1]) cfg_o[i][15:8] <= s_wdata[15:8];
            end
        end
    end

    always_comb begin
        rd_val = '0;
        if (s_araddr == OFS_STATUS) begin
            rd_val = {rd_cap_i, 14'b0, busy_i, locked_i};
        end else if (s_araddr == OFS_CTRL) begin
            rd_val = {30'b0, ctrl_q};
        end else if (r_cfg_hit) begin
            for (int unsigned i = 0; i < NUM_CFG; i++)
                if (roff[AXI_AW-1:2] == 10'(i))
                    rd_val = {16'b0, cfg_o[i]};
        end
    end

endmodule

// File: rtl/clkcfg_seq.sv
module clkcfg_seq
    import clkcfg_pkg::*;
#(
    parameter int unsigned NUM_CFG = 4
) (
    input  logic                            clk,
    input  logic                            srst,
    input  logic                            start_i,
    input  logic [NUM_CFG-1:0][PORT_DW-1:0] cfg_i,
    input  logic                            rdy_i,
    input  logic [PORT_DW-1:0]              rdata_i,
    input  logic                            locked_i,
    output logic                            en_o,
    output logic                            we_o,
    output logic [PORT_AW-1:0]              addr_o,
    output logic [PORT_DW-1:0]              wdata_o,
    output logic                            busy_o,
    output logic                            hold_o,
    output logic                            port_rst_o,
    output logic [PORT_DW-1:0]              rd_cap_o
);

    localparam int unsigned CW   = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;
    localparam logic [CW-1:0] LAST = CW'(NUM_CFG - 1);

    seq_state_e   state_q;
    logic [CW-1:0] idx_q, idx_nxt;
    port_xfer_t   xfer_q;

    assign idx_nxt    = idx_q + 1'b1;
    assign en_o       = (state_q == SQ_ISSUE);
    assign we_o       = en_o;
    assign addr_o     = xfer_q.addr;
    assign wdata_o    = xfer_q.data;
    assign busy_o     = (state_q != SQ_IDLE);
    assign hold_o     = busy_o;
    assign port_rst_o = (state_q == SQ_ISSUE) || (state_q == SQ_WAIT_RDY);

    always_ff @(posedge clk) begin
        if (srst) begin
            state_q  <= SQ_IDLE;
            idx_q    <= '0;
            xfer_q   <= '0;
            rd_cap_o <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (start_i) begin
                        idx_q       <= '0;
                        xfer_q.addr <= cfg_port_addr(0);
                        xfer_q.data <= cfg_i[0];
                        state_q     <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: state_q <= SQ_WAIT_RDY;
                SQ_WAIT_RDY: begin
                    if (rdy_i) begin
                        rd_cap_o <= rdata_i;
                        if (idx_q == LAST) begin
                            state_q <= SQ_WAIT_LOCK;
                        end else begin
                            idx_q       <= idx_nxt;
                            xfer_q.addr <= cfg_port_addr(int'(idx_nxt));
                            xfer_q.data <= cfg_i[idx_nxt];
                            state_q     <= SQ_ISSUE;
                        end
                    end
                end
                SQ_WAIT_LOCK: if (locked_i) state_q <= SQ_IDLE;
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/clk_reconfig_ctrl.sv
module clk_reconfig_ctrl
    import clkcfg_pkg::*;
#(
    parameter int unsigned NUM_CFG   = 4,
    parameter int unsigned RST_PULSE = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [11:0]        s_awaddr,
    input  logic               s_awvalid,
    output logic               s_awready,
    input  logic [31:0]        s_wdata,
    input  logic [3:0]         s_wstrb,
    input  logic               s_wvalid,
    output logic               s_wready,
    output logic [1:0]         s_bresp,
    output logic               s_bvalid,
    input  logic               s_bready,
    input  logic [11:0]        s_araddr,
    input  logic               s_arvalid,
    output logic               s_arready,
    output logic [31:0]        s_rdata,
    output logic [1:0]         s_rresp,
    output logic               s_rvalid,
    input  logic               s_rready,
    output logic [6:0]         port_addr_o,
    output logic [15:0]        port_wdata_o,
    input  logic [15:0]        port_rdata_i,
    output logic               port_en_o,
    output logic               port_we_o,
    input  logic               port_rdy_i,
    output logic               gen_rst_o,
    output logic               clk_hold_o,
    input  logic               gen_locked_i
);

    localparam int unsigned PW = $clog2(RST_PULSE + 1);

    logic [NUM_CFG-1:0][PORT_DW-1:0] cfg;
    logic                start, soft_rst, srst, busy, seq_port_rst;
    logic [PORT_DW-1:0]  rd_cap;
    logic [PW-1:0]       pulse_q;

    assign srst = rst | soft_rst;

    clkcfg_axil_regs #(.NUM_CFG(NUM_CFG)) i_regs (
        .clk(clk), .rst(rst),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .busy_i(busy), .locked_i(gen_locked_i), .rd_cap_i(rd_cap),
        .cfg_o(cfg), .start_o(start), .soft_rst_o(soft_rst)
    );

    clkcfg_seq #(.NUM_CFG(NUM_CFG)) i_seq (
        .clk(clk), .srst(srst), .start_i(start), .cfg_i(cfg),
        .rdy_i(port_rdy_i), .rdata_i(port_rdata_i), .locked_i(gen_locked_i),
        .en_o(port_en_o), .we_o(port_we_o), .addr_o(port_addr_o), .wdata_o(port_wdata_o),
        .busy_o(busy), .hold_o(clk_hold_o), .port_rst_o(seq_port_rst), .rd_cap_o(rd_cap)
    );

    // Generator reset pulse requested from the bus
    always_ff @(posedge clk) begin
        if (rst)
            pulse_q <= '0;
        else if (soft_rst)
            pulse_q <= PW'(RST_PULSE);
        else if (pulse_q != '0)
            pulse_q <= pulse_q - 1'b1;
    end

    assign gen_rst_o = seq_port_rst | (pulse_q != '0);

endmodule

// File: rtl/clkcfg_chk.sv
module clkcfg_chk (
    input logic clk,
    input logic rst,
    input logic port_en_o,
    input logic port_we_o,
    input logic port_rdy_i,
    input logic gen_rst_o,
    input logic clk_hold_o,
    input logic gen_locked_i,
    input logic s_bvalid,
    input logic s_bready
);

    logic pending_q;

    always_ff @(posedge clk) begin
        if (rst)
            pending_q <= 1'b0;
        else if (port_en_o)
            pending_q <= 1'b1;
        else if (port_rdy_i)
            pending_q <= 1'b0;
    end

    // R5
    en_single_chk: assert property (@(posedge clk) disable iff (rst) port_en_o |=> !port_en_o);
    // R5
    en_write_chk: assert property (@(posedge clk) disable iff (rst) port_en_o |-> port_we_o);
    // R5
    en_outstanding_chk: assert property (@(posedge clk) disable iff (rst) port_en_o |-> !pending_q);
    // R6
    en_in_reset_chk: assert property (@(posedge clk) disable iff (rst) port_en_o |-> (gen_rst_o && clk_hold_o));
    // R7
    hold_release_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(clk_hold_o) && !gen_rst_o) |-> $past(gen_locked_i));
    // R3
    bresp_hold_chk: assert property (@(posedge clk) disable iff (rst) (s_bvalid && !s_bready) |=> s_bvalid);

endmodule

bind clk_reconfig_ctrl clkcfg_chk i_chk (
    .clk(clk), .rst(rst), .port_en_o(port_en_o), .port_we_o(port_we_o),
    .port_rdy_i(port_rdy_i), .gen_rst_o(gen_rst_o), .clk_hold_o(clk_hold_o),
    .gen_locked_i(gen_locked_i), .s_bvalid(s_bvalid), .s_bready(s_bready)
);

// File: tb/test_clk_reconfig_ctrl.sv
`timescale 1ns/1ps
module test_clk_reconfig_ctrl;

    localparam int NCFG  = 6;
    localparam int PULSE = 3;
    localparam int LOCK_LAT = 8;

    logic clk = 1'b0, rst = 1'b1;
    always #2 clk = ~clk;

    logic [11:0] awaddr = '0, araddr = '0;
    logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic [6:0]  p_addr;
    logic [15:0] p_wdata, p_rdata = '0, p_lat = '0;
    logic        p_en, p_we, p_rdy = 0, g_rst, c_hold, locked = 0;

    clk_reconfig_ctrl #(.NUM_CFG(NCFG), .RST_PULSE(PULSE)) i_clk_reconfig_ctrl (
        .clk(clk), .rst(rst),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .port_addr_o(p_addr), .port_wdata_o(p_wdata), .port_rdata_i(p_rdata),
        .port_en_o(p_en), .port_we_o(p_we), .port_rdy_i(p_rdy),
        .gen_rst_o(g_rst), .clk_hold_o(c_hold), .gen_locked_i(locked)
    );

    // Behavioural generator: ready two cycles after enable, inverted data back
    int rcnt = 0, lcnt = 0;
    always @(posedge clk) begin
        p_rdy <= 1'b0;
        if (rst) rcnt <= 0;
        else if (p_en) begin rcnt <= 2; p_lat <= p_wdata; end
        else if (rcnt != 0) begin
            rcnt <= rcnt - 1;
            if (rcnt == 1) begin p_rdy <= 1'b1; p_rdata <= ~p_lat; end
        end
        if (g_rst) begin lcnt <= 0; locked <= 1'b0; end
        else if (lcnt < LOCK_LAT) lcnt <= lcnt + 1;
        else locked <= 1'b1;
    end

    // Port monitor
    logic [6:0]  mon_addr [16];
    logic [15:0] mon_data [16];
    int  en_cnt = 0;
    bit  mon_err = 0, pend = 0, hold_prev = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (p_en) begin
                if (!p_we || !g_rst || !c_hold || pend) mon_err = 1;
                if (en_cnt < 16) begin mon_addr[en_cnt] = p_addr; mon_data[en_cnt] = p_wdata; end
                en_cnt++;
                pend = 1;
            end
            if (p_rdy) pend = 0;
            if (hold_prev && !c_hold && !locked && !g_rst) mon_err = 1;
            hold_prev = c_hold;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    function automatic logic [15:0] exp_def(int i);
        return 16'h1041 + 16'(i) * 16'h0203;
    endfunction
    function automatic logic [6:0] exp_paddr(int i);
        return 7'h08 + 7'(i);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic axi_wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s, output logic [1:0] r);
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        r = bresp;
        bready = 1;
        @(negedge clk);
        bready = 0;
    endtask

    task automatic axi_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1;
        @(negedge clk);
        arvalid = 0;
        d = rdata;
        rready = 1;
        @(negedge clk);
        rready = 0;
    endtask

    task automatic wait_idle(input string req);
        int t = 0;
        while (c_hold && t < 2000) begin @(negedge clk); t++; end
        chk(t < 2000, req, 32'(t), 32'd2000);
    endtask

    task automatic wait_locked();
        int t = 0;
        while (!locked && t < 200) begin @(negedge clk); t++; end
    endtask

    task automatic finish_test();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_test();
    end

    initial begin
        logic [31:0] rv;
        logic [1:0]  rs;
        logic [15:0] user [NCFG];
        void'($urandom(32'h5EED_0042));

        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!p_en && !g_rst && !c_hold, "R1 outputs idle", {29'b0, p_en, g_rst, c_hold}, 32'h0);
        for (int i = 0; i < NCFG; i++) begin
            axi_rd(12'h200 + 12'(4 * i), rv);
            chk(rv == {16'b0, exp_def(i)}, "R1 default word", rv, {16'b0, exp_def(i)});
        end
        wait_locked();
        axi_rd(12'h004, rv);
        chk(rv[1] == 1'b0, "R1 busy after reset", rv, 32'h0);
        chk(rv[0] == locked && locked, "R7 status lock bit", rv, 32'h1);

        // R2 random full writes and readback
        for (int i = 0; i < NCFG; i++) begin
            user[i] = 16'($urandom);
            axi_wr(12'h200 + 12'(4 * i), {16'($urandom), user[i]}, 4'hF, rs);
            chk(rs == 2'b00, "R3 OKAY on config write", 32'(rs), 32'h0);
            axi_rd(12'h200 + 12'(4 * i), rv);
            chk(rv == {16'b0, user[i]}, "R2 readback", rv, {16'b0, user[i]});
        end
        // R2 byte strobe: only byte 1 changes
        axi_wr(12'h204, 32'h0000_A55A, 4'b0010, rs);
        user[1] = {8'hA5, user[1][7:0]};
        axi_rd(12'h204, rv);
        chk(rv == {16'b0, user[1]}, "R2 strobe byte1", rv, {16'b0, user[1]});

        // R3 unmapped and misaligned reads, write to unmapped
        axi_rd(12'h008, rv);
        chk(rv == 0, "R3 unmapped read", rv, 0);
        axi_rd(12'h200 + 12'(4 * NCFG), rv);
        chk(rv == 0, "R3 past last word", rv, 0);
        axi_rd(12'h202, rv);
        chk(rv == 0, "R3 misaligned read", rv, 0);
        axi_wr(12'h0F0, 32'hFFFF_FFFF, 4'hF, rs);
        chk(rs == 2'b00, "R3 OKAY unmapped write", 32'(rs), 0);

        // R4 partial control values do nothing
        en_cnt = 0;
        axi_wr(12'h014, 32'h1, 4'hF, rs);
        repeat (10) @(negedge clk);
        axi_rd(12'h014, rv);
        chk(rv == 32'h1 && en_cnt == 0 && !c_hold, "R4 enable only", rv, 32'h1);
        axi_wr(12'h014, 32'h2, 4'hF, rs);
        repeat (10) @(negedge clk);
        axi_rd(12'h014, rv);
        chk(rv == 32'h2 && en_cnt == 0 && !c_hold, "R4 load only", rv, 32'h2);

        // Three full loads with fresh random data
        for (int run = 0; run < 3; run++) begin
            if (run > 0)
                for (int i = 0; i < NCFG; i++) begin
                    user[i] = 16'($urandom);
                    axi_wr(12'h200 + 12'(4 * i), {16'b0, user[i]}, 4'hF, rs);
                end
            en_cnt = 0; mon_err = 0;
            axi_wr(12'h014, 32'h3, 4'hF, rs);
            chk(c_hold == 1'b1, "R6 hold raised on start", {31'b0, c_hold}, 1);
            axi_rd(12'h014, rv);
            chk(rv == 0, "R4 control self-clears", rv, 0);
            wait_idle("R7 sequence completes");
            chk(en_cnt == NCFG, "R5 write count", 32'(en_cnt), 32'(NCFG));
            for (int i = 0; i < NCFG; i++)
                chk(mon_addr[i] == exp_paddr(i) && mon_data[i] == user[i], "R5 address and data",
                    {9'b0, mon_addr[i], mon_data[i]}, {9'b0, exp_paddr(i), user[i]});
            chk(!mon_err, "R6 reset and hold during writes", {31'b0, mon_err}, 0);
            axi_rd(12'h004, rv);
            chk(rv[1] == 0 && rv[0] == 1, "R7 busy cleared and locked", rv, {~user[NCFG-1], 16'h1});
            chk(rv[31:16] == ~user[NCFG-1], "R10 captured read data", rv, {~user[NCFG-1], 16'h1});
        end

        // R8 configuration write while busy is ignored
        en_cnt = 0;
        axi_wr(12'h014, 32'h3, 4'hF, rs);
        axi_wr(12'h200, 32'h0000_BEEF ^ {16'b0, user[0]}, 4'hF, rs);
        chk(rs == 2'b00, "R8 OKAY while busy", 32'(rs), 0);
        wait_idle("R8 sequence completes");
        axi_rd(12'h200, rv);
        chk(rv == {16'b0, user[0]}, "R8 word unchanged", rv, {16'b0, user[0]});

        // R9 wrong key has no effect
        axi_wr(12'h000, 32'h5, 4'hF, rs);
        repeat (3) @(negedge clk);
        axi_rd(12'h200, rv);
        chk(rv == {16'b0, user[0]} && !g_rst, "R9 wrong key ignored", rv, {16'b0, user[0]});

        // R9 abort a running sequence
        wait_locked();
        en_cnt = 0;
        axi_wr(12'h014, 32'h3, 4'hF, rs);
        while (en_cnt < 1) @(negedge clk);
        axi_wr(12'h000, 32'h0000_000A, 4'hF, rs);
        begin
            int plen = 0;
            chk(!c_hold, "R9 hold released on abort", {31'b0, c_hold}, 0);
            while (g_rst && plen < 50) begin @(negedge clk); plen++; end
            chk(plen == PULSE, "R9 reset pulse length", 32'(plen), 32'(PULSE));
        end
        for (int i = 0; i < NCFG; i++) begin
            axi_rd(12'h200 + 12'(4 * i), rv);
            chk(rv == {16'b0, exp_def(i)}, "R9 defaults restored", rv, {16'b0, exp_def(i)});
        end
        axi_rd(12'h004, rv);
        chk(rv[1] == 0 && rv[31:16] == 0, "R9 status cleared", rv, {16'b0, 15'b0, rv[0]});

        repeat (20) @(negedge clk);
        finish_test();
    end

endmodule